// File: doc/BRIEF.md
# Frequency-Balancing Cell Boundary Allocator

This block divides a bank of identical power cells between two output channels, A and B. The assignment is a thermometer-coded select vector. A 1 in bit n gives cell n to channel A and a 0 gives it to channel B, so channel A always holds a contiguous run of cells starting at bit 0. The number of set bits is the A cell count.

The block measures the switching period of each channel clock by counting cycles of a faster measurement clock. Both channel clocks enter the measurement domain through synchronizers. Once both periods are known, the block compares them against a programmable hysteresis window. The faster, more heavily loaded channel then gains exactly one cell at the boundary. When the two periods agree within the window, the block raises stop and leaves the split alone.

After each decision, the block waits a fixed idle gap and then takes a fresh pair of measurements. This keeps boundary moves much slower than each channel's own regulation loop.

Top module: `fbal_alloc`

## Requirements
- R1: While reset is low (synchronous, active low), sel loads the thermometer code of init_cnt, clamped to the range [MINCELL, NCELL-MINCELL]. In that code, bits 0 to k-1 are 1 for an A count of k. Also during reset, dir, stop and busy are 0.
- R2: sel is a valid thermometer code at every clock: a run of ones from bit 0 upward, followed only by zeros.
- R3: Each decision changes at most one bit of sel. A decision is marked by busy falling, and sel, dir and stop take their new values on that same edge.
- R4: Each channel period is the number of measurement-clock cycles between two consecutive rising edges of that channel clock after synchronization. A comparison is made only after both periods are ready.
- R5: If TA + hyst_win < TB (channel A faster), the decision sets dir to 0 and clears stop. It also shifts sel left by one, filling with a 1, so A gains one cell.
- R6: If TB + hyst_win < TA (channel B faster), the decision sets dir to 1 and clears stop. It also shifts sel right by one, filling with a 0, so A loses one cell.
- R7: If |TA - TB| <= hyst_win, the decision sets stop to 1 and leaves both sel and dir unchanged. A difference exactly equal to hyst_win counts as inside the window.
- R8: Once stop is 1, a later decision outside the window clears it and shifting resumes. This happens, for example, after hyst_win is lowered.
- R9: The A count never exceeds NCELL-MINCELL and never falls below MINCELL. A shift request at either limit keeps sel unchanged, still updates dir as in R5 or R6, and still clears stop.
- R10: Consecutive decisions are at least GAP + max(TA, TB) measurement cycles apart. Every decision uses a new measurement of both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_a | input | 1 | Switching clock of channel A (asynchronous) |
| clk_b | input | 1 | Switching clock of channel B (asynchronous) |
| hyst_win | input | CNTW | Hysteresis window in measurement cycles |
| init_cnt | input | CW | A cell count loaded during reset |
| sel | output | NCELL | Thermometer select, 1 = cell on channel A |
| dir | output | 1 | Last shift direction, 0 = toward A, 1 = toward B |
| stop | output | 1 | Periods matched within the window at the last decision |
| busy | output | 1 | High while a measurement and decision are in progress |

## Verification
The bench goes after the window edge, where the period difference equals hyst_win. A design with a strict comparison there would keep shifting where it should set stop. It also drives the boundary into both saturation limits. A design lacking the limit check would wrap, empty a channel, or break the thermometer code.

The bench lowers the window while stop is set. A design that latches stop would never resume shifting. At every decision the bench also checks the one-bit step and the minimum spacing between decisions. A design that reused stale periods, or moved several cells at once, would fail those checks.

// File: rtl/fbal_pkg.sv
package fbal_pkg;
   typedef enum logic [1:0] {S_GAP, S_START, S_WAIT, S_DEC} ctl_state_t;
   typedef enum logic [1:0] {M_IDLE, M_ARM, M_CNT, M_DONE} meter_state_t;
endpackage

// File: rtl/fbal_sync.sv
module fbal_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fbal_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)      chain[i] <= 1'b0;
            else if (i == 0) chain[i] <= d;
            else             chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fbal_period_meter.sv
module fbal_period_meter
   import fbal_pkg::*;
#(
   parameter int CNTW   = 16,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            chan_clk,
   input  logic            start,
   input  logic            clr,
   output logic [CNTW-1:0] period,
   output logic            ready
);
   generate
      if (CNTW < 4) begin : g_bad_cntw
         $error("fbal_period_meter: CNTW must be at least 4");
      end
   endgenerate

   logic         s_now, s_prev, rise;
   logic [CNTW-1:0] cnt;
   meter_state_t st;

   fbal_sync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(chan_clk), .q(s_now)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_now;
   end
   assign rise = s_now & ~s_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= M_IDLE;
         cnt    <= '0;
         period <= '0;
         ready  <= 1'b0;
      end else if (clr) begin
         st    <= M_IDLE;
         ready <= 1'b0;
      end else begin
         unique case (st)
            M_IDLE: if (start) st <= M_ARM;
            M_ARM: if (rise) begin
               cnt <= CNTW'(1);
               st  <= M_CNT;
            end
            M_CNT: begin
               if (rise) begin
                  period <= cnt;
                  ready  <= 1'b1;
                  st     <= M_DONE;
               end else if (cnt != '1) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !clr) |=> ready);                          // R4
   AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (period != '0));                    // R4
endmodule

// File: rtl/fbal_boundary.sv
module fbal_boundary #(
   parameter int NCELL   = 82,
   parameter int MINCELL = 1,
   parameter int CW      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    init_cnt,
   input  logic             step_en,
   input  logic             step_left,
   output logic [NCELL-1:0] sel
);
   generate
      if (MINCELL < 1 || 2*MINCELL > NCELL) begin : g_bad_min
         $error("fbal_boundary: MINCELL out of range");
      end
   endgenerate

   localparam logic [CW-1:0] LO = CW'(MINCELL);
   localparam logic [CW-1:0] HI = CW'(NCELL - MINCELL);

   logic [CW-1:0]    init_c;
   logic [NCELL-1:0] init_vec;
   logic             can_grow, can_shrink;

   always_comb begin
      if (init_cnt < LO)      init_c = LO;
      else if (init_cnt > HI) init_c = HI;
      else                    init_c = init_cnt;
   end

   generate
      for (genvar i = 0; i < NCELL; i++) begin : g_init
         assign init_vec[i] = (init_c > CW'(i));
      end
   endgenerate

   assign can_grow   = ~sel[NCELL-MINCELL-1];
   assign can_shrink = sel[MINCELL];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel <= init_vec;
      end else if (step_en) begin
         if (step_left && can_grow)        sel <= {sel[NCELL-2:0], 1'b1};
         else if (!step_left && can_shrink) sel <= {1'b0, sel[NCELL-1:1]};
      end
   end

   AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel + NCELL'(1)));                          // R2
   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel ^ $past(sel)) <= 1);                  // R3
   AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      sel[MINCELL-1]);                                     // R9
   AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      !sel[NCELL-MINCELL]);                                // R9
endmodule

// File: rtl/fbal_alloc.sv
module fbal_alloc
   import fbal_pkg::*;
#(
   parameter int NCELL   = 82,
   parameter int MINCELL = 1,
   parameter int CNTW    = 16,
   parameter int STAGES  = 2,
   parameter int GAP     = 4,
   localparam int CW     = $clog2(NCELL + 1),
   localparam int GW     = $clog2(GAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic [CNTW-1:0]  hyst_win,
   input  logic [CW-1:0]    init_cnt,
   output logic [NCELL-1:0] sel,
   output logic             dir,
   output logic             stop,
   output logic             busy
);
   generate
      if (NCELL < 4) begin : g_bad_ncell
         $error("fbal_alloc: NCELL must be at least 4");
      end
      if (GAP < STAGES + 2) begin : g_bad_gap
         $error("fbal_alloc: GAP must cover synchronizer settling");
      end
   endgenerate

   ctl_state_t      st;
   logic [GW-1:0]   gap_cnt;
   logic            start, clr;
   logic [CNTW-1:0] per_a, per_b;
   logic            rdy_a, rdy_b;
   logic            a_fast, b_fast, step_en;

   assign start = (st == S_START);
   assign clr   = (st == S_GAP);
   assign busy  = (st != S_GAP);

   fbal_period_meter #(.CNTW(CNTW), .STAGES(STAGES)) u_meter_a (
      .clk(clk), .rst_n(rst_n), .chan_clk(clk_a), .start(start),
      .clr(clr), .period(per_a), .ready(rdy_a)
   );
   fbal_period_meter #(.CNTW(CNTW), .STAGES(STAGES)) u_meter_b (
      .clk(clk), .rst_n(rst_n), .chan_clk(clk_b), .start(start),
      .clr(clr), .period(per_b), .ready(rdy_b)
   );

   assign a_fast  = ({1'b0, per_a} + {1'b0, hyst_win}) < {1'b0, per_b};
   assign b_fast  = ({1'b0, per_b} + {1'b0, hyst_win}) < {1'b0, per_a};
   assign step_en = (st == S_DEC) && (a_fast || b_fast);

   fbal_boundary #(.NCELL(NCELL), .MINCELL(MINCELL), .CW(CW)) u_bound (
      .clk(clk), .rst_n(rst_n), .init_cnt(init_cnt),
      .step_en(step_en), .step_left(a_fast), .sel(sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_GAP;
         gap_cnt <= '0;
         dir     <= 1'b0;
         stop    <= 1'b0;
      end else begin
         unique case (st)
            S_GAP: begin
               if (gap_cnt == GW'(GAP - 1)) begin
                  gap_cnt <= '0;
                  st      <= S_START;
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            S_START: st <= S_WAIT;
            S_WAIT:  if (rdy_a && rdy_b) st <= S_DEC;
            S_DEC: begin
               if (a_fast) begin
                  dir  <= 1'b0;
                  stop <= 1'b0;
               end else if (b_fast) begin
                  dir  <= 1'b1;
                  stop <= 1'b0;
               end else begin
                  stop <= 1'b1;
               end
               st <= S_GAP;
            end
            default: st <= S_GAP;
         endcase
      end
   end

   AST_DEC_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEC) |-> (rdy_a && rdy_b));                 // R4
   AST_LEFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEC && a_fast) |=> (!dir && !stop));        // R5
   AST_RIGHT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEC && b_fast) |=> (dir && !stop));         // R6
   AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEC && !a_fast && !b_fast) |=> (stop && $stable(sel) && $stable(dir))); // R7
   AST_GAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> !busy);                              // R10
endmodule

// File: tb/fbal_alloc_tb.sv
module fbal_alloc_tb;
   localparam int N    = 82;
   localparam int MINC = 1;
   localparam int CNTW = 16;
   localparam int GAP  = 4;
   localparam int CW   = $clog2(N + 1);

   typedef struct {
      int cnt;
      bit dir;
      bit stp;
      int pmax;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_a = 1'b0, clk_b = 1'b0;
   logic [CNTW-1:0] hyst_win = '0;
   logic [CW-1:0]   init_cnt = CW'(41);
   logic [N-1:0]    sel;
   logic            dir, stop, busy;

   int total = 0, bad = 0, cyc = 0;
   int pa = 8, pb = 8;
   int ca = 0, cb = 0;
   int m_cnt, hw;
   bit m_dir;
   exp_t q[$];

   always #2 clk = ~clk;

   fbal_alloc #(.NCELL(N), .MINCELL(MINC), .CNTW(CNTW), .STAGES(2), .GAP(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_a(clk_a), .clk_b(clk_b),
      .hyst_win(hyst_win), .init_cnt(init_cnt),
      .sel(sel), .dir(dir), .stop(stop), .busy(busy)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      ca  <= (ca >= pa - 1) ? 0 : ca + 1;
      cb  <= (cb >= pb - 1) ? 0 : cb + 1;
      clk_a <= (ca < pa / 2);
      clk_b <= (cb < pb / 2);
   end

   function automatic logic [N-1:0] therm(input int k);
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (i < k);
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string msg,
                        input logic [127:0] act, input logic [127:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, expv);
      end
   endtask

   task automatic push_dec(input int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         if (pa + hw < pb) begin
            m_dir = 1'b0;
            if (m_cnt < N - MINC) m_cnt++;
            e.stp = 1'b0;
         end else if (pb + hw < pa) begin
            m_dir = 1'b1;
            if (m_cnt > MINC) m_cnt--;
            e.stp = 1'b0;
         end else begin
            e.stp = 1'b1;
         end
         e.cnt  = m_cnt;
         e.dir  = m_dir;
         e.pmax = (pa > pb) ? pa : pb;
         q.push_back(e);
      end
   endtask

   task automatic drain();
      while (q.size() != 0 && cyc < 150000) @(negedge clk);
   endtask

   // R1: reset state and init clamp
   task automatic do_reset(input int init, input int expc, input int npa, input int npb);
      @(negedge clk);
      rst_n = 1'b0;
      init_cnt = CW'(init);
      pa = npa;
      pb = npb;
      repeat (5) @(negedge clk);
      check(sel === therm(expc), "R1", "reset sel", sel, therm(expc));
      check({dir, stop, busy} === 3'b000, "R1", "reset dir/stop/busy", {dir, stop, busy}, 0);
      m_cnt = expc;
      m_dir = 1'b0;
      rst_n = 1'b1;
   endtask

   // scoreboard monitor: R2 R3 R10 plus per-decision values
   initial begin
      logic busy_q = 1'b0;
      logic [N-1:0] prev = '0;
      int last = 0;
      bit have_last = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            busy_q = 1'b0;
            prev = sel;
            have_last = 1'b0;
         end else begin
            if (busy_q && !busy && q.size() != 0) begin
               exp_t e;
               e = q.pop_front();
               check(sel === therm(e.cnt), "R5/R6/R9", "sel after decision", sel, therm(e.cnt));
               check(dir === e.dir, "R5/R6", "dir", dir, e.dir);
               check(stop === e.stp, "R7/R8", "stop", stop, e.stp);
               check($onehot0(sel + N'(1)), "R2", "thermometer", sel, 0);
               check($countones(sel ^ prev) <= 1, "R3", "one bit per decision", sel ^ prev, 0);
               if (have_last)
                  check(cyc - last >= GAP + e.pmax, "R10", "decision spacing",
                        cyc - last, GAP + e.pmax);
               last = cyc;
               have_last = 1'b1;
            end
            if (busy_q && !busy) prev = sel;
            busy_q = busy;
         end
      end
   end

   initial begin
      // clamp checks, R1
      do_reset(0, MINC, 8, 8);
      do_reset(100, N - MINC, 8, 8);
      // R5: A faster, shifts left
      hw = 2; hyst_win = CNTW'(hw);
      do_reset(41, 41, 8, 16);
      push_dec(4); drain();
      // R6: B faster, shifts right
      do_reset(41, 41, 24, 12);
      push_dec(3); drain();
      // R7 window edge (diff == hyst) then R8 resume after lowering
      do_reset(30, 30, 20, 22);
      push_dec(2); drain();
      hw = 1; hyst_win = CNTW'(hw);
      push_dec(2); drain();
      // R9 upper saturation
      hw = 2; hyst_win = CNTW'(hw);
      do_reset(80, 80, 8, 16);
      push_dec(3); drain();
      // R9 lower saturation
      do_reset(2, 2, 16, 8);
      push_dec(3); drain();
      if (cyc >= 150000) begin
         total++; bad++;
         $display("FAIL watchdog: timeout actual=%0d expected<%0d", cyc, 150000);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc >= 160000);
      total++; bad++;
      $display("FAIL watchdog: hung actual=%0d expected<%0d", cyc, 160000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule